// File: doc/BRIEF.md
# Clustered lane broadcast unit

This block is the lane-permutation step a SIMD shader core uses to build prefix-sum style subgroup reductions. The subgroup is cut into equal clusters of 2, 4, 8 or 16 lanes. In every cluster, each active lane of the upper half takes the value of one chosen lane from the lower half. The chosen lane is the highest-numbered active lane of that lower half, which is lane N/2-1 whenever that lane is active. All other lanes keep their current destination value.

Each request supplies these inputs:
- the source vector (one opaque word per lane)
- the current destination vector
- a per-lane active mask
- a 2-bit cluster-size code
- a valid strobe

One cycle later the block presents the updated destination vector with an output valid pulse. Every cluster is handled in parallel in the same way. Write masks, register-file access and type handling belong to the surrounding pipeline.

Top module: `lane_bcast_unit`

## Requirements
- R1: The cluster size N is 2 shifted left by `csize_code`: code 0 gives 2 lanes, code 1 gives 4, code 2 gives 8 and code 3 gives 16. Cluster k covers lanes k*N to k*N+N-1.
- R2: When lane N/2-1 of a cluster is active, every active lane in the upper half of that cluster (offsets N/2 to N-1) receives that lane's source word.
- R3: Lanes in the lower half of a cluster (offsets 0 to N/2-1) always output their own destination word.
- R4: When lane N/2-1 is inactive, the broadcast value is the source word of the highest active lane below it in the lower half.
- R5: An inactive lane in the upper half outputs its own destination word.
- R6: When no lane in a cluster's lower half is active, every lane of that cluster outputs its own destination word.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_vec` changes only in that cycle and otherwise holds its last value.
- R8: Clusters are independent. The result in one cluster depends only on the mask and data of that cluster's own lanes.
- R9: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| csize_code | input | 2 | Cluster size code, N = 2 << code |
| active_mask | input | LANES | Per-lane active flag, bit i for lane i |
| src_vec | input | LANES*DW | Source words, lane i at bits [i*DW +: DW] |
| dst_vec | input | LANES*DW | Current destination words, same packing |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_vec | output | LANES*DW | Updated destination words, same packing |

## Verification
All state lives in the result register and the valid flag, so a fault appears on the very next clock edge after the request it corrupts. A wrong lane pick shows up as an upper-half lane carrying another lane's source word. A broken enable shows up as `out_vec` moving in an idle cycle, or as `out_valid` out of step with `in_valid`. The bench compares every lane of every result, and every idle cycle, against a behavioural model. Directed cases cover each cluster size, the fallback search, an empty lower half and an inactive upper lane.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  // Cluster size encodings; the value selects N = 2 << code.
  typedef enum logic [1:0] {
    CSZ_2  = 2'd0,
    CSZ_4  = 2'd1,
    CSZ_8  = 2'd2,
    CSZ_16 = 2'd3
  } csize_e;

  localparam int unsigned NUM_SIZES   = 4;
  localparam int unsigned MAX_CLUSTER = 2 << (NUM_SIZES - 1);

  // Lanes per cluster for a size code.
  function automatic int unsigned cluster_lanes(input int unsigned code);
    return 2 << code;
  endfunction

  // Encoder direction: code for a cluster of n lanes.
  function automatic int unsigned size_to_code(input int unsigned n);
    return $clog2(n) - 1;
  endfunction

endpackage

// File: rtl/lbc_half_pick.sv
// Picks the highest active lane of one lower half-cluster.
module lbc_half_pick #(
  parameter int unsigned HALF = 4,
  parameter int unsigned DW   = 32
) (
  input  logic [HALF-1:0]    act_lo,
  input  logic [HALF*DW-1:0] val_lo,
  output logic               hit,
  output logic [DW-1:0]      pick
);

  // Ascending scan: the last active lane seen wins, i.e. the highest.
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = 0; i < HALF; i++) begin
      if (act_lo[i]) begin
        hit  = 1'b1;
        pick = val_lo[i*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/lbc_size_plane.sv
// Per-lane update enable and value for one fixed cluster size.
module lbc_size_plane #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned CODE  = 0
) (
  input  logic [LANES-1:0]    act,
  input  logic [LANES*DW-1:0] src,
  output logic [LANES-1:0]    upd,
  output logic [LANES*DW-1:0] val
);

  localparam int unsigned N    = lbc_pkg::cluster_lanes(CODE);
  localparam int unsigned HALF = N / 2;
  localparam int unsigned NCL  = LANES / N;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    logic          hit_c;
    logic [DW-1:0] pick_c;
    // Upper-half sources are never a broadcast origin at this size.
    logic [HALF*DW-1:0] src_hi_unused;
    assign src_hi_unused = src[(c*N + HALF)*DW +: HALF*DW];

    lbc_half_pick #(.HALF(HALF), .DW(DW)) u_pick (
      .act_lo (act[c*N +: HALF]),
      .val_lo (src[c*N*DW +: HALF*DW]),
      .hit    (hit_c),
      .pick   (pick_c)
    );

    for (genvar j = 0; j < N; j++) begin : g_ln
      if (j < HALF) begin : g_lo
        assign upd[c*N + j]             = 1'b0;
        assign val[(c*N + j)*DW +: DW]  = pick_c;
      end else begin : g_hi
        assign upd[c*N + j]             = hit_c & act[c*N + j];
        assign val[(c*N + j)*DW +: DW]  = pick_c;
      end
    end
  end

endmodule

// File: rtl/lane_bcast_unit.sv
module lane_bcast_unit
  import lbc_pkg::*;
#(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          csize_code,
  input  logic [LANES-1:0]    active_mask,
  input  logic [LANES*DW-1:0] src_vec,
  input  logic [LANES*DW-1:0] dst_vec,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_vec
);

  localparam int unsigned VW = LANES * DW;

  if (LANES % MAX_CLUSTER != 0) begin : g_bad_lanes
    $error("LANES must be a multiple of the largest cluster size");
  end

  logic [LANES-1:0] upd_k [NUM_SIZES];
  logic [VW-1:0]    val_k [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_plane
    lbc_size_plane #(.LANES(LANES), .DW(DW), .CODE(k)) u_plane (
      .act (active_mask),
      .src (src_vec),
      .upd (upd_k[k]),
      .val (val_k[k])
    );
  end

  // Next-state logic
  csize_e        sel;
  logic [VW-1:0] vec_d;
  logic          vld_d;
  logic          vec_en;

  assign sel    = csize_e'(csize_code);
  assign vld_d  = in_valid;
  assign vec_en = in_valid;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      vec_d[l*DW +: DW] = upd_k[sel][l] ? val_k[sel][l*DW +: DW]
                                        : dst_vec[l*DW +: DW];
    end
  end

  // Registers
  logic          vld_q;
  logic [VW-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (vec_en) vec_q <= vec_d;
  end

  assign out_valid = vld_q;
  assign out_vec   = vec_q;

endmodule

// File: rtl/lbc_chk.sv
module lbc_chk #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          csize_code,
  input logic [LANES-1:0]    active_mask,
  input logic [LANES*DW-1:0] src_vec,
  input logic [LANES*DW-1:0] dst_vec,
  input logic                out_valid,
  input logic [LANES*DW-1:0] out_vec
);

  localparam int unsigned VW = LANES * DW;

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));

  // Lane 0 is in a lower half at every cluster size.
  p_lower_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[DW-1:0] == $past(dst_vec[DW-1:0]));

  // The last lane is in an upper half at every cluster size.
  p_idle_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !active_mask[LANES-1]
    |=> out_vec[VW-1 -: DW] == $past(dst_vec[VW-1 -: DW]));

  p_none_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (active_mask == '0) |=> out_vec == $past(dst_vec));

  p_pair_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (csize_code == 2'd0) && (active_mask[1:0] == 2'b11)
    |=> out_vec[2*DW-1:DW] == $past(src_vec[DW-1:0]));

  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_clear_r9: assert (out_valid == 1'b0);
    end
  end

endmodule

bind lane_bcast_unit lbc_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .csize_code  (csize_code),
  .active_mask (active_mask),
  .src_vec     (src_vec),
  .dst_vec     (dst_vec),
  .out_valid   (out_valid),
  .out_vec     (out_vec)
);

// File: tb/sim_lane_bcast_unit.sv
`timescale 1ns/1ps
module sim_lane_bcast_unit;

  localparam int LANES = 64;
  localparam int DW    = 32;
  localparam int VW    = LANES * DW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [1:0]       csize_code;
  logic [LANES-1:0] active_mask;
  logic [VW-1:0]    src_vec, dst_vec;
  logic             out_valid;
  logic [VW-1:0]    out_vec;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  lane_bcast_unit #(.LANES(LANES), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .csize_code(csize_code),
    .active_mask(active_mask), .src_vec(src_vec), .dst_vec(dst_vec),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [DW-1:0] sv(input int seed, input int l);
    return {16'hA000 + 16'(seed), 16'(l)};
  endfunction
  function automatic logic [DW-1:0] dv(input int seed, input int l);
    return {16'hD000 + 16'(seed), 16'(l)};
  endfunction

  // Behavioural reference for the whole subgroup.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] s,
      input logic [VW-1:0] d, input logic [LANES-1:0] a, input int code);
    logic [VW-1:0] r;
    int n;
    n = 2 << code;
    r = d;
    for (int l = 0; l < LANES; l++) begin
      int base;
      int off;
      base = (l / n) * n;
      off  = l % n;
      if (off >= n/2 && a[l]) begin
        for (int j = n/2 - 1; j >= 0; j--) begin
          if (a[base + j]) begin
            r[l*DW +: DW] = s[(base + j)*DW +: DW];
            break;
          end
        end
      end
    end
    return r;
  endfunction

  // Expected-output tracking and per-clock comparison
  string         cur_tag = "R8";
  string         exp_tag = "R7";
  logic          exp_v   = 1'b0;
  logic          have    = 1'b0;
  logic [VW-1:0] exp_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_vec <= model(src_vec, dst_vec, active_mask, int'(csize_code));
        exp_tag <= cur_tag;
        have    <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      n_chk++;
      if (out_valid !== exp_v) begin
        n_err++;
        $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, exp_v);
      end
      if (have) begin
        n_chk++;
        if (out_vec !== exp_vec) begin
          n_err++;
          for (int l = 0; l < LANES; l++) begin
            if (out_vec[l*DW +: DW] !== exp_vec[l*DW +: DW]) begin
              $display("FAIL %s lane %0d actual=%h expected=%h (valid=%0b)",
                       exp_v ? exp_tag : "R7", l, out_vec[l*DW +: DW],
                       exp_vec[l*DW +: DW], exp_v);
              break;
            end
          end
        end
      end
    end
  end

  task automatic op(input int code, input logic [LANES-1:0] a,
                    input int seed, input string tag);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      src_vec[l*DW +: DW] = sv(seed, l);
      dst_vec[l*DW +: DW] = dv(seed, l);
    end
    active_mask = a;
    csize_code  = 2'(code);
    cur_tag     = tag;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic lane_chk(input int l, input logic [DW-1:0] e, input string tag);
    n_chk++;
    if (out_vec[l*DW +: DW] !== e) begin
      n_err++;
      $display("FAIL %s lane %0d actual=%h expected=%h", tag, l,
               out_vec[l*DW +: DW], e);
    end
  endtask

  localparam logic [LANES-1:0] ALL = '1;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; csize_code = 2'd0;
    active_mask = '0; src_vec = '0; dst_vec = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R9 out_valid actual=%0b expected=0", out_valid);
    end
    rst_n = 1'b1;

    // Size 8, all active
    op(2, ALL, 1, "R2");
    lane_chk(5, sv(1, 3), "R2");
    lane_chk(13, sv(1, 11), "R1");
    lane_chk(3, dv(1, 3), "R3");
    // Size 8, lanes 2 and 3 inactive
    op(2, ALL & ~64'h0C, 2, "R4");
    lane_chk(4, sv(2, 1), "R4");
    lane_chk(2, dv(2, 2), "R3");
    // Sizes 2, 4, 16
    op(0, ALL, 3, "R1");
    lane_chk(1, sv(3, 0), "R1");
    lane_chk(3, sv(3, 2), "R1");
    op(1, ALL, 4, "R1");
    lane_chk(3, sv(4, 1), "R1");
    lane_chk(2, sv(4, 1), "R1");
    op(3, ALL, 5, "R1");
    lane_chk(8, sv(5, 7), "R1");
    lane_chk(31, sv(5, 23), "R1");
    // Empty lower half in cluster 0 only
    op(2, ALL & ~64'h0F, 6, "R6");
    lane_chk(5, dv(6, 5), "R6");
    lane_chk(12, sv(6, 11), "R8");
    // Inactive upper lane
    op(2, ALL & ~64'h40, 7, "R5");
    lane_chk(6, dv(7, 6), "R5");
    lane_chk(7, sv(7, 3), "R5");
    // Fallback to lane 0 at size 16
    op(3, ALL & ~64'hFE, 8, "R4");
    lane_chk(15, sv(8, 0), "R4");
    lane_chk(5, dv(8, 5), "R3");
    // Idle cycles hold the result
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R7 idle out_valid actual=%0b expected=0", out_valid);
    end
    lane_chk(15, sv(8, 0), "R7");

    // Random traffic, back-to-back and gapped
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        src_vec[l*DW +: DW] = $urandom;
        dst_vec[l*DW +: DW] = $urandom;
      end
      active_mask = {$urandom, $urandom};
      if (it % 3 == 0) active_mask = active_mask & {$urandom, $urandom};
      csize_code = 2'($urandom);
      cur_tag    = "R8";
      in_valid   = ($urandom % 10) < 7;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule